// File: doc/BRIEF.md
# Configurable 16-bit Event Timer

A single counter channel that advances either on every system clock or on each cycle of an external horizontal-blank strobe. Software sets it up through three word registers (count, mode and target) on a simple 32-bit register bus. The counter can restart from zero after it holds the target value, or it can run to the all-ones value and wrap. An active-low interrupt line reports target and all-ones events. The line can fire once per arming or on every event, and it can either dip low for one clock or change level on each event.

Two sticky flags record that the target value or the all-ones value was reached. Both clear when the mode register is read. A gating input, together with a sync enable bit and a two-bit sync selection in the mode register, can pause counting. The register bus has no handshake and no back-pressure. A write strobe takes effect at the clock edge where it is sampled. Read data is combinational from the address, so it is valid in the same cycle as the read strobe.

Top module: `strobe_timer`

## Requirements
- R1: After reset, the count register (address 0) reads 0, the target register (address 2) reads 0, and the mode register (address 1) reads 0x400. That value is line idle with all mode fields zero.
- R2: Mode bits 9:8 select the count source. With values 0 or 2 the counter advances on every clock. With values 1 or 3 it advances only in cycles where `blank_strobe` is 1.
- R3: While mode bit 0 is 1, mode bits 2:1 gate counting. Value 0 pauses while `sync_gate` is 1, value 1 pauses while `sync_gate` is 0, and values 2 or 3 pause at all times.
- R4: With mode bit 3 at 0, a count step from 0xFFFF gives 0. With mode bit 3 at 1, a count step taken while the counter equals the target gives 0.
- R5: Mode read bit 11 is set when a step makes the counter equal the target. Bit 12 is set when a step makes it 0xFFFF. Both stay set until a read of the mode register, and a new event in the same cycle as that read wins over the clear.
- R6: A target event raises a request only when mode bit 4 is 1. An all-ones event raises a request only when mode bit 5 is 1.
- R7: With mode bit 6 at 0, only the first request after a mode write reaches `irq_n`. With mode bit 6 at 1, every request reaches it.
- R8: With mode bit 7 at 0, each request drives `irq_n` low for exactly one clock, after which it returns high.
- R9: With mode bit 7 at 1, each request inverts `irq_n`.
- R10: A write to the mode register sets the counter to 0, drives `irq_n` high, and re-arms one-shot requests.
- R11: A write to address 0 loads the counter from bits 15:0. A write to address 2 sets the target.
- R12: Mode read bit 10 always equals the `irq_n` pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a mode read clears the sticky flags) |
| bus_addr | input | 2 | Word select: 0 count, 1 mode, 2 target |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| blank_strobe | input | 1 | External blank strobe used as the count source |
| sync_gate | input | 1 | Level that gates counting when sync is enabled |
| irq_n | output | 1 | Active-low interrupt request line |

## Verification
Every counter step, flag update and change on `irq_n` appears one clock after the edge that samples its cause. A write takes effect at the edge that samples the strobe. Read data reflects the present register state within the same cycle. The bench drives its inputs just after the falling edge and compares `irq_n` with its model on every falling edge. It checks read data one time unit after it sets up a read, before the next rising edge. Interval checks count low cycles of `irq_n` between marks, so a pulse that is one cycle too long or too short shows up in the counts.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
  localparam logic [1:0] ADDR_TARGET = 2'd2;
  localparam int MODE_W   = 10;
  localparam int IRQ_BIT  = 10;
  localparam int FTGT_BIT = 11;
  localparam int FMAX_BIT = 12;

  // Packed MSB first: bits 9:8 src ... bit 0 sync_en
  typedef struct packed {
    logic [1:0] src;
    logic       toggle;
    logic       rpt;
    logic       irq_max;
    logic       irq_tgt;
    logic       rst_on_tgt;
    logic [1:0] sync_sel;
    logic       sync_en;
  } mode_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen (
  input  logic       ext_src,
  input  logic       sync_en,
  input  logic [1:0] sync_sel,
  input  logic       blank_strobe,
  input  logic       sync_gate,
  output logic       tick
);
  logic pause;

  always_comb begin
    pause = 1'b0;
    if (sync_en) begin
      if (sync_sel[1])      pause = 1'b1;
      else if (sync_sel[0]) pause = ~sync_gate;
      else                  pause = sync_gate;
    end
    tick = ~pause & (ext_src ? blank_strobe : 1'b1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rst_on_tgt,
  input  logic [CNT_W-1:0] target,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_tgt,
  output logic             hit_max
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    if (rst_on_tgt && cnt == target) nxt = '0;
    else                              nxt = cnt + 1'b1;
    hit_tgt = tick && (nxt == target);
    hit_max = tick && (nxt == MAX_VAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= nxt;
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_tgt,
  input  logic hit_max,
  input  logic en_tgt,
  input  logic en_max,
  input  logic rpt,
  input  logic toggle,
  input  logic rearm,
  input  logic clr_flags,
  output logic irq_n,
  output logic flag_tgt,
  output logic flag_max
);
  logic armed;
  logic fire;

  assign fire = ((en_tgt & hit_tgt) | (en_max & hit_max)) & (rpt | armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      irq_n <= 1'b1;
    end else if (rearm) begin
      armed <= 1'b1;
      irq_n <= 1'b1;
    end else begin
      if (fire && !rpt) armed <= 1'b0;
      if (toggle) irq_n <= fire ? ~irq_n : irq_n;
      else        irq_n <= ~fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_tgt <= 1'b0;
      flag_max <= 1'b0;
    end else begin
      flag_tgt <= hit_tgt | (flag_tgt & ~clr_flags);
      flag_max <= hit_max | (flag_max & ~clr_flags);
    end
  end
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              blank_strobe,
  input  logic              sync_gate,
  output logic              irq_n
);
  import timer_pkg::*;

  mode_t            mode_q;
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_w, hit_tgt, hit_max, flag_tgt, flag_max;
  logic             wr_mode, wr_count, wr_target, rd_mode;

  assign wr_mode   = bus_wr && bus_addr == ADDR_MODE;
  assign wr_count  = bus_wr && bus_addr == ADDR_COUNT;
  assign wr_target = bus_wr && bus_addr == ADDR_TARGET;
  assign rd_mode   = bus_rd && bus_addr == ADDR_MODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      target_q <= '0;
    end else begin
      if (wr_mode)   mode_q   <= mode_t'(bus_wdata[MODE_W-1:0]);
      if (wr_target) target_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_COUNT:  bus_rdata[CNT_W-1:0] = cnt_q;
      ADDR_MODE: begin
        bus_rdata[MODE_W-1:0] = mode_q;
        bus_rdata[IRQ_BIT]    = irq_n;
        bus_rdata[FTGT_BIT]   = flag_tgt;
        bus_rdata[FMAX_BIT]   = flag_max;
      end
      ADDR_TARGET: bus_rdata[CNT_W-1:0] = target_q;
      default:     bus_rdata = '0;
    endcase
  end

  tmr_tick_gen u_tick (
    .ext_src      (mode_q.src[0]),
    .sync_en      (mode_q.sync_en),
    .sync_sel     (mode_q.sync_sel),
    .blank_strobe (blank_strobe),
    .sync_gate    (sync_gate),
    .tick         (tick_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .rst_on_tgt (mode_q.rst_on_tgt),
    .target     (target_q),
    .clear      (wr_mode),
    .load       (wr_count),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .cnt        (cnt_q),
    .hit_tgt    (hit_tgt),
    .hit_max    (hit_max)
  );

  tmr_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_tgt   (hit_tgt),
    .hit_max   (hit_max),
    .en_tgt    (mode_q.irq_tgt),
    .en_max    (mode_q.irq_max),
    .rpt       (mode_q.rpt),
    .toggle    (mode_q.toggle),
    .rearm     (wr_mode),
    .clr_flags (rd_mode),
    .irq_n     (irq_n),
    .flag_tgt  (flag_tgt),
    .flag_max  (flag_max)
  );
endmodule

// File: rtl/strobe_timer_chk.sv
module strobe_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic             irq_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] target,
  input logic             tick,
  input logic             rst_on_tgt,
  input logic             ext_src,
  input logic             blank_strobe,
  input logic             sync_en,
  input logic             sync_hold,
  input logic             flag_tgt
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  // R10
  mode_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> (irq_n && cnt == '0));

  // R4
  tgt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rst_on_tgt && cnt == target && !bus_wr) |=> cnt == '0);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rst_on_tgt && cnt == ALL1 && !bus_wr) |=> cnt == '0);

  // R2
  ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ext_src) |-> blank_strobe);

  // R3
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && sync_hold) |-> !tick);

  // R5
  tgt_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_tgt) |-> $past(tick));
endmodule

bind strobe_timer strobe_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .irq_n        (irq_n),
  .cnt          (cnt_q),
  .target       (target_q),
  .tick         (tick_w),
  .rst_on_tgt   (mode_q.rst_on_tgt),
  .ext_src      (mode_q.src[0]),
  .blank_strobe (blank_strobe),
  .sync_en      (mode_q.sync_en),
  .sync_hold    (mode_q.sync_sel[1]),
  .flag_tgt     (flag_tgt)
);

// File: tb/test_strobe_timer.sv
`timescale 1ns/1ps
module test_strobe_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        blank_strobe = 1'b0, sync_gate = 1'b0;
  logic        irq_n;

  int checks = 0, fails = 0, lowcnt = 0, lc0 = 0;

  always #2 clk = ~clk;

  strobe_timer i_strobe_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .blank_strobe(blank_strobe), .sync_gate(sync_gate), .irq_n(irq_n)
  );

  // Behavioural reference model
  logic [15:0] m_cnt, m_tgt;
  logic [9:0]  m_mode;
  logic        m_ft, m_fm, m_irqn, m_armed;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_tgt = 0; m_mode = 0; m_ft = 0; m_fm = 0;
      m_irqn = 1; m_armed = 1;
    end else begin
      bit run, ht, hm, fire;
      logic [15:0] after;
      run = 1;
      if (m_mode[0]) begin
        case (m_mode[2:1])
          2'd0: run = !sync_gate;
          2'd1: run = sync_gate;
          default: run = 0;
        endcase
      end
      if (m_mode[8] && !blank_strobe) run = 0;
      after = (m_mode[3] && m_cnt == m_tgt) ? 16'd0 : m_cnt + 16'd1;
      ht = run && after == m_tgt;
      hm = run && after == 16'hFFFF;
      fire = ((m_mode[4] && ht) || (m_mode[5] && hm)) && (m_mode[6] || m_armed);
      if (bus_rd && bus_addr == 2'd1) begin m_ft = 0; m_fm = 0; end
      if (ht) m_ft = 1;
      if (hm) m_fm = 1;
      if (fire && !m_mode[6]) m_armed = 0;
      if (m_mode[7]) begin if (fire) m_irqn = !m_irqn; end
      else m_irqn = !fire;
      if (run) m_cnt = after;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: m_cnt = bus_wdata[15:0];
          2'd1: begin m_mode = bus_wdata[9:0]; m_cnt = 0; m_irqn = 1; m_armed = 1; end
          2'd2: m_tgt = bus_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_n == 1'b0) lowcnt++;
      checks++;
      if (irq_n !== m_irqn) begin
        fails++;
        $display("FAIL R12 irq_n pin: actual %0b expected %0b at %0t", irq_n, m_irqn, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  function automatic logic [31:0] model_word(input logic [1:0] a);
    case (a)
      2'd0: return {16'd0, m_cnt};
      2'd1: return {19'd0, m_fm, m_ft, m_irqn, m_mode};
      2'd2: return {16'd0, m_tgt};
      default: return 32'd0;
    endcase
  endfunction

  // read, compare against model and optionally against a literal
  task automatic rd(input logic [1:0] a, input string tag, input bit lit, input logic [31:0] exp);
    bus_rd = 1; bus_addr = a;
    #1;
    chk(tag, bus_rdata, model_word(a));
    if (lit) chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic mark();
    #1 lc0 = lowcnt;
  endtask

  task automatic lows(input string tag, input int exp);
    #1 chk(tag, lowcnt - lc0, exp);
  endtask

  task automatic strobe();
    blank_strobe = 1; @(negedge clk);
    blank_strobe = 0; @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    // R1 reset state
    rd(2'd1, "R1 mode", 1, 32'h400);
    rd(2'd2, "R1 target", 1, 32'h0);
    wr(2'd1, 32'h005);           // sync mode 2: hold
    rd(2'd0, "R1/R10 count", 1, 32'h0);

    // R11 loads
    wr(2'd0, 32'h1234);
    rd(2'd0, "R11 count load", 1, 32'h1234);
    wr(2'd2, 32'h5);
    rd(2'd2, "R11 target", 1, 32'h5);

    // R8 pulse, repeat, restart at target
    wr(2'd1, 32'h58);
    rd(2'd0, "R10 zero after mode write", 1, 32'h0);
    mark(); cyc(5);
    lows("R8 one low cycle", 1);
    chk("R8 line back high", {31'd0, irq_n}, 32'h1);
    cyc(12);
    rd(2'd0, "R4 restart at target", 0, 0);
    rd(2'd1, "R5 target flag", 0, 0);
    rd(2'd1, "R5 flag clear on read", 0, 0);

    // R7 one-shot vs repeat (target 2, period 3)
    wr(2'd2, 32'h2);
    wr(2'd1, 32'h18);
    mark(); cyc(12);
    lows("R7 one-shot single request", 1);
    wr(2'd1, 32'h18);
    mark(); cyc(6);
    lows("R7 rearmed by mode write", 1);
    wr(2'd1, 32'h58);
    mark(); cyc(12);
    lows("R7 repeat every event", 4);

    // R6 no enables
    wr(2'd1, 32'h08);
    mark(); cyc(20);
    lows("R6 no request without enable", 0);
    rd(2'd1, "R6 flag still set", 0, 0);

    // R9 toggle (target 3)
    wr(2'd2, 32'h3);
    wr(2'd1, 32'hD8);
    cyc(4);
    chk("R9 first toggle", {31'd0, irq_n}, 32'h0);
    cyc(4);
    chk("R9 second toggle", {31'd0, irq_n}, 32'h1);
    rd(2'd1, "R12 bit10 matches pin", 0, 0);

    // R4 wrap and R5 all-ones flag, all-ones one-shot request
    wr(2'd1, 32'h20);
    wr(2'd0, 32'hFFFE);
    mark(); cyc(2);
    rd(2'd0, "R4 wrap to zero", 1, 32'h0);
    lows("R6 all-ones request", 1);
    rd(2'd1, "R5 all-ones flag", 0, 0);

    // R2 source select
    wr(2'd1, 32'h100);
    strobe(); strobe(); strobe();
    rd(2'd0, "R2 strobe source", 1, 32'h3);
    wr(2'd1, 32'h300);
    strobe(); strobe();
    rd(2'd0, "R2 source 3", 1, 32'h2);
    wr(2'd1, 32'h200);
    cyc(7);
    rd(2'd0, "R2 source 2 clock", 1, 32'h7);

    // R3 sync gating
    sync_gate = 1;
    wr(2'd1, 32'h001);
    cyc(5);
    sync_gate = 0; cyc(4); sync_gate = 1;
    rd(2'd0, "R3 sel0 pause on high", 1, 32'h4);
    wr(2'd1, 32'h003);
    cyc(3); sync_gate = 0; cyc(5);
    rd(2'd0, "R3 sel1 pause on low", 1, 32'h3);
    wr(2'd1, 32'h005);
    sync_gate = 1; cyc(3); sync_gate = 0; cyc(3);
    rd(2'd0, "R3 sel2 hold", 1, 32'h0);

    cyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule